// File: doc/BRIEF.md
# I2C Controller Control and Request Slice

This block holds the software-visible control state of an I2C peripheral and turns it into the signals the rest of the peripheral acts on. Software writes two 16-bit words: a control word (peripheral enable, I2C/SMBus mode, acknowledge enable and the one-shot START, STOP and PEC commands) and a configuration word (bus clock frequency code, interrupt enables and DMA controls). A bus engine, outside this block, reports busy/idle, buffer status, event flags and error flags. It also returns an accept pulse for each command it takes.

From these the block builds an event interrupt, an error interrupt, a DMA request and the ACK/NACK decision for the byte being received. A disable written while the engine is busy is held back until the engine goes idle. A DMA "last" setting makes the final DMA-counted byte of a master receive answered with NACK. All outputs are registered. Reads have one cycle of latency.

Top module: `i2cc_ctrl`

## Requirements
- R1: After a synchronous reset every output is 0 and both words read back as 0x0000.
- R2: Reserved bits read as 0 even after being written with 1. The control word keeps only bits 0 (enable), 1 (SMBus mode), 8 (START), 9 (STOP), 10 (ACK enable) and 12 (PEC), giving mask 0x1703. The configuration word keeps bits 5:0 (frequency), 8 (error irq enable), 9 (event irq enable), 10 (buffer irq enable), 11 (DMA enable) and 12 (DMA last), giving mask 0x1F3F.
- R3: Writing enable=0 while `eng_busy` is low clears `periph_en` at that write's clock edge. If `eng_busy` is high, `periph_en` stays 1 until the first edge at which `eng_busy` is sampled low. Writing enable=1 cancels a pending disable.
- R4: When `periph_en` is 0, START, STOP, PEC and ACK enable are held at 0. Command writes made while disabled have no effect.
- R5: A control write with a 1 in the START, STOP or PEC position raises that command while enabled. A 0 written there does not clear it. The command clears at the edge where its accept pulse is sampled.
- R6: A START write that arrives while START is already pending is ignored. If the accept pulse arrives in the same cycle, START ends cleared.
- R7: `dma_req` is high, one cycle after its inputs, when enabled, DMA is enabled and `eng_txe` or `eng_rxne` is high.
- R8: With the buffer irq enable set, `eng_txe` or `eng_rxne` raises `irq_evt` one cycle later whatever the DMA enable is. With the enable clear, those two inputs raise no interrupt.
- R9: Start-sent, address-matched, byte-finished and stop-detected flags raise `irq_evt` one cycle later only when the event irq enable is set.
- R10: Bus-error, arbitration-lost, ack-failure and overrun flags raise `irq_err` one cycle later only when the error irq enable is set.
- R11: `ack_out` is 1 one cycle after enable and ACK enable are both set. It drops to 0 (NACK) while DMA enable, DMA last, `eng_master_rx` and `dma_final` are all high.
- R12: `smbus_mode` and `bus_freq` follow the written mode bit and frequency field from the edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 configuration |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read target: 0 control, 1 configuration |
| rd_data | output | 16 | Registered read data |
| eng_busy | input | 1 | Engine is mid-transfer |
| eng_txe | input | 1 | Transmit buffer empty |
| eng_rxne | input | 1 | Receive buffer not empty |
| eng_sb | input | 1 | Start condition sent |
| eng_addr | input | 1 | Address sent/matched |
| eng_btf | input | 1 | Byte transfer finished |
| eng_stopf | input | 1 | Stop detected |
| eng_berr | input | 1 | Bus error |
| eng_arlo | input | 1 | Arbitration lost |
| eng_af | input | 1 | Acknowledge failure |
| eng_ovr | input | 1 | Overrun/underrun |
| eng_take_start | input | 1 | Engine accepted START |
| eng_take_stop | input | 1 | Engine accepted STOP |
| eng_take_pec | input | 1 | Engine accepted PEC |
| eng_master_rx | input | 1 | Engine is master receiver |
| dma_final | input | 1 | Byte in progress is the last of the DMA count |
| cmd_start | output | 1 | Pending START command |
| cmd_stop | output | 1 | Pending STOP command |
| cmd_pec | output | 1 | Pending PEC command |
| periph_en | output | 1 | Effective peripheral enable |
| smbus_mode | output | 1 | 0 I2C, 1 SMBus |
| bus_freq | output | 6 | Bus clock frequency code |
| irq_evt | output | 1 | Event interrupt |
| irq_err | output | 1 | Error interrupt |
| dma_req | output | 1 | DMA request |
| ack_out | output | 1 | 1 ACK, 0 NACK for the byte being received |

## Verification
The checker watches, on every cycle, the cause side of the outputs: the enable never drops while the engine is busy, no command survives while disabled or past its accept pulse, a DMA request or error interrupt always has a buffer or error flag behind it, and no ACK is given under the final-DMA-byte condition. Other behaviour needs the directed scenarios. These cover the reserved-bit masks, set-only command writes, a START collision with its accept pulse, the buffer interrupt under both DMA settings, the enable gating of each interrupt source, and NACK on the final byte only.

// File: rtl/i2cc_pkg.sv
package i2cc_pkg;
  localparam int DW     = 16;
  localparam int FREQ_W = 6;

  // control word bit positions
  localparam int C_EN    = 0;
  localparam int C_SMB   = 1;
  localparam int C_START = 8;
  localparam int C_STOP  = 9;
  localparam int C_ACK   = 10;
  localparam int C_PEC   = 12;
  // configuration word bit positions
  localparam int G_ERRIE = 8;
  localparam int G_EVTIE = 9;
  localparam int G_BUFIE = 10;
  localparam int G_DMAEN = 11;
  localparam int G_LAST  = 12;

  localparam int N_EVT = 4;
  localparam int N_ERR = 4;

  typedef struct packed {
    logic en;
    logic smbus;
    logic start;
    logic stop;
    logic pec;
    logic ack;
  } ctl_t;

  typedef struct packed {
    logic [FREQ_W-1:0] freq;
    logic              err_ie;
    logic              evt_ie;
    logic              buf_ie;
    logic              dma_en;
    logic              dma_last;
  } cfg_t;
endpackage

// File: rtl/i2cc_regs.sv
module i2cc_regs
  import i2cc_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic              eng_busy,
  input  logic              take_start,
  input  logic              take_stop,
  input  logic              take_pec,
  output ctl_t              ctl_q,
  output cfg_t              cfg_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [DATA_W-1:0] CTL_MASK =
    DATA_W'((1 << C_EN) | (1 << C_SMB) | (1 << C_START) | (1 << C_STOP) | (1 << C_ACK) | (1 << C_PEC));
  localparam logic [DATA_W-1:0] CFG_MASK =
    DATA_W'(((1 << FREQ_W) - 1) | (1 << G_ERRIE) | (1 << G_EVTIE) | (1 << G_BUFIE) | (1 << G_DMAEN) | (1 << G_LAST));

  ctl_t ctl_n;
  cfg_t cfg_n;
  logic dis_pend, dis_n;
  logic [DATA_W-1:0] ctl_word, cfg_word;
  logic unused_bits;

  assign unused_bits = ^(wr_data & ~(CTL_MASK | CFG_MASK));

  always_comb begin
    ctl_n = ctl_q;
    cfg_n = cfg_q;
    dis_n = dis_pend;
    if (take_start) ctl_n.start = 1'b0;
    if (take_stop)  ctl_n.stop  = 1'b0;
    if (take_pec)   ctl_n.pec   = 1'b0;
    if (wr_en && !wr_sel) begin
      ctl_n.smbus = wr_data[C_SMB];
      ctl_n.ack   = wr_data[C_ACK];
      if (ctl_q.en) begin
        if (wr_data[C_START] && !ctl_q.start) ctl_n.start = 1'b1;
        if (wr_data[C_STOP]  && !ctl_q.stop)  ctl_n.stop  = 1'b1;
        if (wr_data[C_PEC]   && !ctl_q.pec)   ctl_n.pec   = 1'b1;
      end
      if (wr_data[C_EN]) begin
        ctl_n.en = 1'b1;
        dis_n    = 1'b0;
      end else if (ctl_q.en) begin
        if (eng_busy) dis_n = 1'b1;
        else          ctl_n.en = 1'b0;
      end
    end
    if (dis_pend && !eng_busy) begin
      ctl_n.en = 1'b0;
      dis_n    = 1'b0;
    end
    if (!ctl_n.en) begin
      ctl_n.start = 1'b0;
      ctl_n.stop  = 1'b0;
      ctl_n.pec   = 1'b0;
      ctl_n.ack   = 1'b0;
    end
    if (wr_en && wr_sel) begin
      cfg_n.freq     = wr_data[FREQ_W-1:0];
      cfg_n.err_ie   = wr_data[G_ERRIE];
      cfg_n.evt_ie   = wr_data[G_EVTIE];
      cfg_n.buf_ie   = wr_data[G_BUFIE];
      cfg_n.dma_en   = wr_data[G_DMAEN];
      cfg_n.dma_last = wr_data[G_LAST];
    end
  end

  always_comb begin
    ctl_word          = '0;
    ctl_word[C_EN]    = ctl_q.en;
    ctl_word[C_SMB]   = ctl_q.smbus;
    ctl_word[C_START] = ctl_q.start;
    ctl_word[C_STOP]  = ctl_q.stop;
    ctl_word[C_ACK]   = ctl_q.ack;
    ctl_word[C_PEC]   = ctl_q.pec;
    cfg_word             = '0;
    cfg_word[FREQ_W-1:0] = cfg_q.freq;
    cfg_word[G_ERRIE]    = cfg_q.err_ie;
    cfg_word[G_EVTIE]    = cfg_q.evt_ie;
    cfg_word[G_BUFIE]    = cfg_q.buf_ie;
    cfg_word[G_DMAEN]    = cfg_q.dma_en;
    cfg_word[G_LAST]     = cfg_q.dma_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q    <= '0;
      cfg_q    <= '0;
      dis_pend <= 1'b0;
      rd_data  <= '0;
    end else begin
      ctl_q    <= ctl_n;
      cfg_q    <= cfg_n;
      dis_pend <= dis_n;
      rd_data  <= rd_sel ? cfg_word : ctl_word;
    end
  end
endmodule

// File: rtl/i2cc_req.sv
module i2cc_req #(
  parameter int  NUM_EVT       = 4,
  parameter int  NUM_ERR       = 4,
  parameter bit  BUF_NEEDS_EVT = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               evt_ie,
  input  logic               err_ie,
  input  logic               buf_ie,
  input  logic               dma_en,
  input  logic               txe,
  input  logic               rxne,
  input  logic [NUM_EVT-1:0] evt_flags,
  input  logic [NUM_ERR-1:0] err_flags,
  output logic               irq_evt,
  output logic               irq_err,
  output logic               dma_req
);
  logic buf_hit, buf_gate;

  assign buf_hit = txe | rxne;

  generate
    if (BUF_NEEDS_EVT) begin : g_buf_and_evt
      assign buf_gate = buf_ie & evt_ie;
    end else begin : g_buf_alone
      assign buf_gate = buf_ie;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_evt <= 1'b0;
      irq_err <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq_evt <= en & ((evt_ie & (|evt_flags)) | (buf_gate & buf_hit));
      irq_err <= en & err_ie & (|err_flags);
      dma_req <= en & dma_en & buf_hit;
    end
  end
endmodule

// File: rtl/i2cc_ack.sv
module i2cc_ack (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack_en,
  input  logic dma_en,
  input  logic dma_last,
  input  logic master_rx,
  input  logic dma_final,
  output logic ack_out
);
  logic force_nack;

  assign force_nack = dma_en & dma_last & master_rx & dma_final;

  always_ff @(posedge clk) begin
    if (rst) ack_out <= 1'b0;
    else     ack_out <= en & ack_en & ~force_nack;
  end
endmodule

// File: rtl/i2cc_ctrl.sv
module i2cc_ctrl
  import i2cc_pkg::*;
#(
  parameter int DATA_W = DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_busy,
  input  logic              eng_txe,
  input  logic              eng_rxne,
  input  logic              eng_sb,
  input  logic              eng_addr,
  input  logic              eng_btf,
  input  logic              eng_stopf,
  input  logic              eng_berr,
  input  logic              eng_arlo,
  input  logic              eng_af,
  input  logic              eng_ovr,
  input  logic              eng_take_start,
  input  logic              eng_take_stop,
  input  logic              eng_take_pec,
  input  logic              eng_master_rx,
  input  logic              dma_final,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_pec,
  output logic              periph_en,
  output logic              smbus_mode,
  output logic [FREQ_W-1:0] bus_freq,
  output logic              irq_evt,
  output logic              irq_err,
  output logic              dma_req,
  output logic              ack_out
);
  ctl_t ctl_q;
  cfg_t cfg_q;

  i2cc_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .eng_busy   (eng_busy),
    .take_start (eng_take_start),
    .take_stop  (eng_take_stop),
    .take_pec   (eng_take_pec),
    .ctl_q      (ctl_q),
    .cfg_q      (cfg_q),
    .rd_data    (rd_data)
  );

  i2cc_req #(.NUM_EVT(N_EVT), .NUM_ERR(N_ERR), .BUF_NEEDS_EVT(1'b0)) u_req (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl_q.en),
    .evt_ie    (cfg_q.evt_ie),
    .err_ie    (cfg_q.err_ie),
    .buf_ie    (cfg_q.buf_ie),
    .dma_en    (cfg_q.dma_en),
    .txe       (eng_txe),
    .rxne      (eng_rxne),
    .evt_flags ({eng_sb, eng_addr, eng_btf, eng_stopf}),
    .err_flags ({eng_berr, eng_arlo, eng_af, eng_ovr}),
    .irq_evt   (irq_evt),
    .irq_err   (irq_err),
    .dma_req   (dma_req)
  );

  i2cc_ack u_ack (
    .clk       (clk),
    .rst       (rst),
    .en        (ctl_q.en),
    .ack_en    (ctl_q.ack),
    .dma_en    (cfg_q.dma_en),
    .dma_last  (cfg_q.dma_last),
    .master_rx (eng_master_rx),
    .dma_final (dma_final),
    .ack_out   (ack_out)
  );

  assign cmd_start  = ctl_q.start;
  assign cmd_stop   = ctl_q.stop;
  assign cmd_pec    = ctl_q.pec;
  assign periph_en  = ctl_q.en;
  assign smbus_mode = ctl_q.smbus;
  assign bus_freq   = cfg_q.freq;
endmodule

// File: rtl/i2cc_ctrl_chk.sv
module i2cc_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic periph_en,
  input logic eng_busy,
  input logic cmd_start,
  input logic cmd_stop,
  input logic cmd_pec,
  input logic eng_take_start,
  input logic eng_txe,
  input logic eng_rxne,
  input logic irq_err,
  input logic err_any,
  input logic dma_req,
  input logic ack_out,
  input logic dma_on,
  input logic last_on,
  input logic eng_master_rx,
  input logic dma_final
);
  // R3
  defer_disable_chk: assert property (@(posedge clk) disable iff (rst)
    periph_en && eng_busy |=> periph_en);

  // R4
  idle_cmds_chk: assert property (@(posedge clk) disable iff (rst)
    !periph_en |-> !cmd_start && !cmd_stop && !cmd_pec);

  // R5
  start_taken_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_start && eng_take_start |=> !cmd_start);

  // R7
  dma_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> $past(eng_txe || eng_rxne));

  // R10
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_err |-> $past(err_any));

  // R11
  final_nack_chk: assert property (@(posedge clk) disable iff (rst)
    ack_out |-> !$past(dma_on && last_on && eng_master_rx && dma_final));
endmodule

bind i2cc_ctrl i2cc_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .periph_en      (periph_en),
  .eng_busy       (eng_busy),
  .cmd_start      (cmd_start),
  .cmd_stop       (cmd_stop),
  .cmd_pec        (cmd_pec),
  .eng_take_start (eng_take_start),
  .eng_txe        (eng_txe),
  .eng_rxne       (eng_rxne),
  .irq_err        (irq_err),
  .err_any        (eng_berr | eng_arlo | eng_af | eng_ovr),
  .dma_req        (dma_req),
  .ack_out        (ack_out),
  .dma_on         (cfg_q.dma_en),
  .last_on        (cfg_q.dma_last),
  .eng_master_rx  (eng_master_rx),
  .dma_final      (dma_final)
);

// File: tb/i2cc_ctrl_tb.sv
module i2cc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic eng_busy = 0, eng_txe = 0, eng_rxne = 0, eng_sb = 0, eng_addr = 0;
  logic eng_btf = 0, eng_stopf = 0, eng_berr = 0, eng_arlo = 0, eng_af = 0, eng_ovr = 0;
  logic eng_take_start = 0, eng_take_stop = 0, eng_take_pec = 0;
  logic eng_master_rx = 0, dma_final = 0;
  logic cmd_start, cmd_stop, cmd_pec, periph_en, smbus_mode;
  logic [5:0] bus_freq;
  logic irq_evt, irq_err, dma_req, ack_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2cc_ctrl u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .eng_busy(eng_busy), .eng_txe(eng_txe),
    .eng_rxne(eng_rxne), .eng_sb(eng_sb), .eng_addr(eng_addr), .eng_btf(eng_btf),
    .eng_stopf(eng_stopf), .eng_berr(eng_berr), .eng_arlo(eng_arlo), .eng_af(eng_af),
    .eng_ovr(eng_ovr), .eng_take_start(eng_take_start), .eng_take_stop(eng_take_stop),
    .eng_take_pec(eng_take_pec), .eng_master_rx(eng_master_rx), .dma_final(dma_final),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_pec(cmd_pec), .periph_en(periph_en),
    .smbus_mode(smbus_mode), .bus_freq(bus_freq), .irq_evt(irq_evt), .irq_err(irq_err),
    .dma_req(dma_req), .ack_out(ack_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic sel, output logic [15:0] v);
    rd_sel = sel;
    tick();
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 outputs", {cmd_start, cmd_stop, cmd_pec, periph_en, smbus_mode,
                         irq_evt, irq_err, dma_req, ack_out}, 16'h0);
    check("R1 freq", {10'h0, bus_freq}, 16'h0);
    rd(1'b0, v); check("R1 ctl read", v, 16'h0000);
    rd(1'b1, v); check("R1 cfg read", v, 16'h0000);
  endtask

  task automatic t_reserved();
    logic [15:0] v;
    wr(1'b1, 16'hFFFF);
    rd(1'b1, v); check("R2 cfg mask", v, 16'h1F3F);
    check("R12 freq all ones", {10'h0, bus_freq}, 16'h003F);
    wr(1'b1, 16'h0015);
    check("R12 freq value", {10'h0, bus_freq}, 16'h0015);
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0001);
    wr(1'b0, 16'hFFFF);
    rd(1'b0, v); check("R2 ctl mask", v, 16'h1703);
    check("R12 smbus", {15'h0, smbus_mode}, 16'h1);
    eng_take_start = 1; eng_take_stop = 1; eng_take_pec = 1;
    tick();
    eng_take_start = 0; eng_take_stop = 0; eng_take_pec = 0;
    check("R5 all taken", {13'h0, cmd_start, cmd_stop, cmd_pec}, 16'h0);
    wr(1'b0, 16'h0001);
  endtask

  task automatic t_oneshot();
    wr(1'b0, 16'h0101);
    check("R5 start set", {15'h0, cmd_start}, 16'h1);
    tick();
    check("R5 start held", {15'h0, cmd_start}, 16'h1);
    wr(1'b0, 16'h0001);
    check("R5 zero write keeps start", {15'h0, cmd_start}, 16'h1);
    eng_take_start = 1; tick(); eng_take_start = 0;
    check("R5 start cleared", {15'h0, cmd_start}, 16'h0);
    wr(1'b0, 16'h0101);
    eng_take_start = 1;
    wr(1'b0, 16'h0101);
    eng_take_start = 0;
    check("R6 second start ignored", {15'h0, cmd_start}, 16'h0);
  endtask

  task automatic t_defer();
    logic [15:0] v;
    wr(1'b0, 16'h0301);
    eng_busy = 1;
    wr(1'b0, 16'h0000);
    check("R3 deferred en", {15'h0, periph_en}, 16'h1);
    tick(); tick(); tick();
    check("R3 still en while busy", {15'h0, periph_en}, 16'h1);
    check("R4 cmds kept while busy", {14'h0, cmd_start, cmd_stop}, 16'h3);
    eng_busy = 0;
    tick();
    check("R3 disabled at idle", {15'h0, periph_en}, 16'h0);
    check("R4 cmds cleared", {14'h0, cmd_start, cmd_stop}, 16'h0);
    rd(1'b0, v); check("R4 ctl after disable", v, 16'h0000);
    wr(1'b0, 16'h0100);
    check("R4 start ignored while off", {15'h0, cmd_start}, 16'h0);
    wr(1'b0, 16'h0001);
    wr(1'b0, 16'h0000);
    check("R3 immediate disable", {15'h0, periph_en}, 16'h0);
    wr(1'b0, 16'h0001);
  endtask

  task automatic t_dma();
    wr(1'b1, 16'h0800);
    eng_txe = 1; tick();
    check("R7 dma on txe", {15'h0, dma_req}, 16'h1);
    eng_txe = 0; eng_rxne = 1; tick();
    check("R7 dma on rxne", {15'h0, dma_req}, 16'h1);
    eng_rxne = 0; tick();
    check("R7 dma idle", {15'h0, dma_req}, 16'h0);
    wr(1'b1, 16'h0000);
    eng_txe = 1; tick();
    check("R7 dma disabled", {15'h0, dma_req}, 16'h0);
    eng_txe = 0;
  endtask

  task automatic t_bufirq();
    eng_txe = 1;
    wr(1'b1, 16'h0C00); tick();
    check("R8 buf irq with dma", {15'h0, irq_evt}, 16'h1);
    wr(1'b1, 16'h0400); tick();
    check("R8 buf irq without dma", {15'h0, irq_evt}, 16'h1);
    wr(1'b1, 16'h0800); tick();
    check("R8 no buf irq when clear", {14'h0, irq_evt, dma_req}, 16'h1);
    eng_txe = 0;
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_evt_err();
    eng_sb = 1; tick();
    check("R9 gated off", {15'h0, irq_evt}, 16'h0);
    wr(1'b1, 16'h0200); tick();
    check("R9 start sent", {15'h0, irq_evt}, 16'h1);
    eng_sb = 0; eng_stopf = 1; tick();
    check("R9 stop detected", {15'h0, irq_evt}, 16'h1);
    eng_stopf = 0; tick();
    check("R9 no flags", {15'h0, irq_evt}, 16'h0);
    eng_af = 1; tick();
    check("R10 gated off", {15'h0, irq_err}, 16'h0);
    wr(1'b1, 16'h0100); tick();
    check("R10 ack failure", {15'h0, irq_err}, 16'h1);
    eng_af = 0; eng_arlo = 1; tick();
    check("R10 arbitration lost", {15'h0, irq_err}, 16'h1);
    eng_arlo = 0; eng_btf = 1; tick();
    check("R10 event flag not error", {14'h0, irq_err, irq_evt}, 16'h0);
    eng_btf = 0;
    wr(1'b1, 16'h0000);
  endtask

  task automatic t_nack();
    wr(1'b0, 16'h0401);
    wr(1'b1, 16'h1800);
    eng_master_rx = 1; tick();
    check("R11 ack normal byte", {15'h0, ack_out}, 16'h1);
    dma_final = 1; tick();
    check("R11 nack final byte", {15'h0, ack_out}, 16'h0);
    dma_final = 0; tick();
    check("R11 ack after final", {15'h0, ack_out}, 16'h1);
    wr(1'b1, 16'h0800);
    dma_final = 1; tick();
    check("R11 ack without last", {15'h0, ack_out}, 16'h1);
    dma_final = 0; eng_master_rx = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_reserved();
    t_oneshot();
    t_defer();
    t_dma();
    t_bufirq();
    t_evt_err();
    t_nack();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hang expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule